// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash device. It decides when a program or erase operation inside the device has finished, and whether it finished cleanly. After `start` it reads the device one byte at a time at the address it was given. It compares bit 7 of each byte with the bit 7 it expects.

Bit 5 of the returned byte reports that the device ran past its internal time limit. Bit 7 can settle in the same read that bit 5 rises. For that reason a set bit 5 never ends the operation by itself: the block reads the same address once more and lets that second byte decide.

When bit 7 matches, the other bits of that byte are not yet reliable. The block therefore makes one more read and presents that byte as the verified data. A poll budget parameter ends the operation as failed if bit 5 never appears. The result is reported as a one-cycle `done` pulse together with `pass` and `fail` levels.

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `done`, `pass`, `fail` and `busy` are all 0.
- R2: Every read holds `rd_req` high with `rd_addr` equal to the `addr` captured at start, until a cycle with `rd_ack` high. The byte on `rd_data` in that cycle is the result of the read.
- R3: A read whose bit 7 equals the expected bit moves the block to its verification read. With `erase` = 0 the expected bit is `exp_data[7]`.
- R4: A read whose bit 7 differs from the expected bit and whose bit 5 is 0 is followed by another read at the same address.
- R5: A polling read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one re-read. If bit 7 of the re-read matches, the block continues as in R3. Otherwise it ends with `fail`.
- R6: With `erase` = 1 at start, the expected bit 7 is 1, whatever the value of `exp_data`.
- R7: After a bit 7 match the block makes one further read and ends with `pass`. `vdata` then holds the byte returned by that further read.
- R8: If `MAX_POLLS` polling reads all show a mismatch with bit 5 at 0, the block ends with `fail` after the last of them.
- R9: `done` is high for exactly one cycle, in the cycle after the final `rd_ack`. In that same cycle exactly one of `pass` and `fail` is 1. Both keep their values until a start is accepted, and both are cleared in the cycle after that start.
- R10: A `start` pulse that arrives while `busy` is 1 has no effect on the address, the expected value or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| erase | input | 1 | 1: operation was an erase, so the expected bit 7 is 1 |
| exp_data | input | 8 | Programmed byte; bit 7 is the expected status bit |
| addr | input | AW | Address to poll |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Time limit or poll budget reached |
| vdata | output | 8 | Byte from the verification read |

## Verification
The hardest case to reach is the one where bit 5 rises and the re-read then shows bit 7 settled. The outcome must be pass, and the stored byte must come from the later verification read rather than from the re-read.

The bench's read responder returns a scripted series of bytes, one per acknowledged read. The scripts place the bit 5 byte on the first read and also on a later one. The re-read byte carries low bits that differ from the final byte, so taking `vdata` from the wrong read is visible in the result.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  localparam int DW       = 8;
  localparam int STAT_BIT = 7;   // completion status bit
  localparam int TMO_BIT  = 5;   // time-limit flag bit

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHK,
    ST_VERIFY
  } st_t;

  typedef enum logic [1:0] {
    VD_MATCH,   // status bit equals wanted value
    VD_WAIT,    // mismatch, no time-limit flag
    VD_TMO      // mismatch with time-limit flag
  } vd_t;

  // Wanted status bit: an erase always ends with ones.
  function automatic logic want_bit(input logic erase, input logic [DW-1:0] exp);
    return erase ? 1'b1 : exp[STAT_BIT];
  endfunction

  function automatic vd_t classify(input logic [DW-1:0] d, input logic want);
    if (d[STAT_BIT] == want) return VD_MATCH;
    else if (d[TMO_BIT])     return VD_TMO;
    else                     return VD_WAIT;
  endfunction
endpackage

// File: rtl/dpoll_eval.sv
module dpoll_eval
  import dpoll_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic          want,
  output vd_t           vd
);
  always_comb vd = classify(data, want);
endmodule

// File: rtl/dpoll_cnt.sv
module dpoll_cnt #(
  parameter int LIMIT = 1024,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last   // the next increment reaches LIMIT
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int AW        = 19,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          erase,
  input  logic [DW-1:0] exp_data,
  input  logic [AW-1:0] addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [DW-1:0] vdata
);
  st_t           st;
  logic [AW-1:0] addr_q;
  logic          want_q;
  vd_t           vd;
  logic          lim_last;

  // named internal events
  logic start_acc, poll_ev, tmo_ev, go_verify, fin_pass_ev, fin_fail_ev, fin_ev;

  dpoll_eval u_eval (.data(rd_data), .want(want_q), .vd(vd));

  dpoll_cnt #(.LIMIT(MAX_POLLS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .inc(poll_ev), .last(lim_last)
  );

  always_comb begin
    start_acc   = start && (st == ST_IDLE);
    poll_ev     = (st == ST_POLL) && rd_ack;
    tmo_ev      = poll_ev && (vd == VD_TMO);
    go_verify   = ((st == ST_POLL) || (st == ST_RECHK)) && rd_ack && (vd == VD_MATCH);
    fin_pass_ev = (st == ST_VERIFY) && rd_ack;
    fin_fail_ev = ((st == ST_RECHK) && rd_ack && (vd != VD_MATCH))
               || (poll_ev && (vd == VD_WAIT) && lim_last);
    fin_ev      = fin_pass_ev || fin_fail_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      want_q <= 1'b0;
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
      vdata  <= '0;
    end else begin
      done <= fin_ev;
      if (start_acc) begin
        st     <= ST_POLL;
        addr_q <= addr;
        want_q <= want_bit(erase, exp_data);
        pass   <= 1'b0;
        fail   <= 1'b0;
        vdata  <= '0;
      end else if (fin_pass_ev) begin
        st    <= ST_IDLE;
        pass  <= 1'b1;
        vdata <= rd_data;
      end else if (fin_fail_ev) begin
        st   <= ST_IDLE;
        fail <= 1'b1;
      end else if (go_verify) begin
        st <= ST_VERIFY;
      end else if (tmo_ev) begin
        st <= ST_RECHK;
      end
    end
  end

  assign rd_req  = (st != ST_IDLE);
  assign busy    = (st != ST_IDLE);
  assign rd_addr = addr_q;
endmodule

// File: rtl/dpoll_chk.sv
module dpoll_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic [7:0]    rd_data,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [7:0]    vdata,
  input logic          start_acc,
  input logic          tmo_ev,
  input logic          fin_ev
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  p_recheck_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> rd_req && !done);

  p_vdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> $past(rd_ack) && vdata == $past(rd_data));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc && !fin_ev |=> $stable(pass) && $stable(fail));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !fin_ev |=> busy && $stable(rd_addr));
endmodule

bind dpoll_ctrl dpoll_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .vdata(vdata), .start_acc(start_acc), .tmo_ev(tmo_ev), .fin_ev(fin_ev)
);

// File: tb/sim_dpoll_ctrl.sv
`timescale 1ns/1ps
module sim_dpoll_ctrl;
  localparam int AW = 12;
  localparam int MP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, erase = 1'b0;
  logic [7:0]    exp_data = '0;
  logic [AW-1:0] addr = '0;
  logic          rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = '0;
  logic          busy, done, pass, fail;
  logic [7:0]    vdata;

  always #2.5 clk = ~clk;   // 200 MHz

  dpoll_ctrl #(.AW(AW), .MAX_POLLS(MP)) u0 (.*);

  int nchk = 0, nbad = 0;
  int nreads = 0, addr_err = 0, lat = 0, wcnt = 0;
  logic [7:0]    resp [4];
  logic [AW-1:0] cur_addr = '0;

  // {erase, exp, r0, r1, r2, r3, pass, nreads[3:0], vdata}
  localparam logic [53:0] VECS [9] = '{
    {1'b0, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 1'b1, 4'd2, 8'h5A},
    {1'b0, 8'h5A, 8'h80, 8'h80, 8'h5A, 8'h5A, 1'b1, 4'd4, 8'h5A},
    {1'b0, 8'h5A, 8'hA0, 8'h1A, 8'h5A, 8'h5A, 1'b1, 4'd3, 8'h5A},
    {1'b0, 8'h5A, 8'hA0, 8'hA0, 8'hA0, 8'hA0, 1'b0, 4'd2, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h40, 8'hFF, 8'hFF, 1'b1, 4'd4, 8'hFF},
    {1'b0, 8'h5A, 8'h80, 8'h80, 8'h80, 8'h80, 1'b0, 4'd6, 8'h00},
    {1'b0, 8'hC3, 8'h43, 8'hC3, 8'h81, 8'h81, 1'b1, 4'd3, 8'h81},
    {1'b0, 8'h5A, 8'h80, 8'h80, 8'hA0, 8'h40, 1'b1, 4'd5, 8'h40},
    {1'b1, 8'h00, 8'h20, 8'h20, 8'h20, 8'h20, 1'b0, 4'd2, 8'h00}
  };
  localparam string VTAG [9] = '{"R3", "R4", "R5", "R5", "R6", "R8", "R3", "R5", "R6"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // read responder: acknowledges after lat idle cycles, one byte per read
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack <= 1'b0;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        wcnt    <= 0;
        rd_ack  <= 1'b1;
        rd_data <= resp[(nreads > 3) ? 3 : nreads];
        if (rd_addr !== cur_addr) addr_err <= addr_err + 1;
        nreads  <= nreads + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic kick(input logic er, input logic [7:0] ex, input logic [AW-1:0] a);
    @(negedge clk);
    nreads = 0; addr_err = 0; cur_addr = a;
    start = 1'b1; erase = er; exp_data = ex; addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R9 done seen", done, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_req", rd_req, 0); chk("R1 done", done, 0);
    chk("R1 pass", pass, 0);     chk("R1 fail", fail, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      logic [53:0] v;
      v = VECS[i];
      lat = i % 3;
      resp[0] = v[44:37]; resp[1] = v[36:29]; resp[2] = v[28:21]; resp[3] = v[20:13];
      kick(v[53], v[52:45], AW'(12'h100 + i));
      wait_done();
      chk(VTAG[i], pass, v[12]);
      chk(VTAG[i], fail, !v[12]);
      chk(VTAG[i], nreads, v[11:8]);
      if (v[12]) chk("R7 vdata", vdata, v[7:0]);
      chk("R2 addr", addr_err, 0);
      @(negedge clk);
      chk("R9 one-cycle done", done, 0);
    end

    // R10: start while busy is ignored
    lat = 4;
    resp[0] = 8'h5A; resp[1] = 8'h3C; resp[2] = 8'h3C; resp[3] = 8'h3C;
    kick(1'b0, 8'h5A, 12'hABC);
    @(negedge clk);
    start = 1'b1; erase = 1'b1; exp_data = 8'h00; addr = 12'h001;
    @(negedge clk);
    start = 1'b0;
    chk("R10 addr kept", rd_addr, 12'hABC);
    wait_done();
    chk("R10 pass", pass, 1);
    chk("R10 reads", nreads, 2);
    chk("R10 vdata", vdata, 8'h3C);

    // R9: results hold, then clear after the next start
    repeat (6) @(negedge clk);
    chk("R9 pass held", pass, 1);
    chk("R9 vdata held", vdata, 8'h3C);
    lat = 0;
    resp[0] = 8'hA0; resp[1] = 8'hA0; resp[2] = 8'hA0; resp[3] = 8'hA0;
    kick(1'b0, 8'h5A, 12'h055);
    chk("R9 pass cleared", pass, 0);
    chk("R9 fail cleared", fail, 0);
    wait_done();
    chk("R5 fail", fail, 1);
    repeat (4) @(negedge clk);
    chk("R9 fail held", fail, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule